// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

This block is a 4,608-bit on-chip memory with a dedicated write port and a dedicated read port. Both ports run on one clock and may both be used in the same cycle. Each port has its own data width, fixed by a parameter. The allowed widths are 18, 9, 4, 2 and 1 bits, which give depths of 256, 512, 1,024, 2,048 and 4,096 words. Because the widths are independent, data can be stored in one shape and read back in another. For example, a producer can write nibbles while a consumer takes the same data out as a serial bit stream.

The array has 256 rows of 18 bits, and each row is two 9-bit lanes. In the 9- and 18-bit modes every bit of a lane can be addressed. In the 4-, 2- and 1-bit modes only the low eight bits of each lane are used, so those modes see 4,096 data bits. A width from the 9/18 group cannot be paired with a width from the 4/2/1 group, and such a pairing fails at elaboration. Narrow words pack little-endian into wider ones: narrow address k sits at bit slot (k mod R) of wide word k/R, where R is the ratio of the two widths.

Top module: `mwram_mixed`

## Requirements
- R1: While reset is asserted, and after it is released until the first read, `rdData` is all zeros.
- R2: A read whose `rdEn` is high at a rising edge shows its data on `rdData` right after that edge, and not earlier.
- R3: When `rdEn` is low, `rdData` keeps its value, even if `rdAddr` changes.
- R4: With a 4-bit write port and a 1-bit read port, bit j of the nibble written at address a reads back at 1-bit address 4a+j (little-endian). This holds for every nibble address 0 to 1023, up to 1-bit address 4095.
- R5: With an 18-bit write port and a 9-bit read port, bits [8:0] of the word written at address r read back at 9-bit address 2r, and bits [17:9] at address 2r+1.
- R6: A cycle with `wrEn` low changes no stored bit, whatever is on `wrAddr` and `wrData`.
- R7: If a read and a write touch the same bits in the same cycle, the read returns the contents from before the write. The write still takes effect and is visible to later reads.
- R8: Address bits above the depth of a port's width are ignored. A 4-bit write to 0x402 lands on nibble 2, an 18-bit write to 0x105 lands on row 5, and a 9-bit read of 0x20B reads address 11.
- R9: A narrow write changes only its own bits. The other words packed into the same row keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Active-low asynchronous reset of the read output register |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 12 | Write address; only the low bits that fit the write depth are used |
| wrData | input | WR_WIDTH | Write data |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 12 | Read address; only the low bits that fit the read depth are used |
| rdData | output | RD_WIDTH | Registered read data |

## Verification
Checks that run on every cycle cover these properties: decoded offsets stay inside a row, written bits land exactly where the mask says, the other bits of a row are left alone, idle cycles leave the row untouched, and the read output holds while reads are off. Other behaviours can only be shown by the bench's scenarios: the little-endian reshaping between the two widths, the split of an 18-bit word into two 9-bit reads, old-data return on a same-cycle read and write, and address aliasing above the configured depth. All of these depend on the exact data values that come back through the read port.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  // Geometry of the shared array
  localparam int ROW_COUNT   = 256;
  localparam int LANE_BITS   = 9;
  localparam int LANE_COUNT  = 2;
  localparam int LANE_DATA   = 8;                        // data bits per lane in narrow modes
  localparam int ROW_BITS    = LANE_BITS * LANE_COUNT;   // 18
  localparam int ROW_IDX_W   = $clog2(ROW_COUNT);        // 8
  localparam int NARROW_ROW  = LANE_DATA * LANE_COUNT;   // 16
  localparam int ADDR_W      = $clog2(ROW_COUNT * NARROW_ROW); // 12
  localparam int OFF_W       = $clog2(ROW_BITS);         // 5
  localparam int UNIT_W      = $clog2(NARROW_ROW);       // 4

  typedef struct packed {
    logic                 wrStb;
    logic [ROW_IDX_W-1:0] wrRow;
    logic [OFF_W-1:0]     wrOffset;
    logic                 rdStb;
    logic [ROW_IDX_W-1:0] rdRow;
    logic [OFF_W-1:0]     rdOffset;
  } ramStrobes_t;

  // Words of a given width that share one physical row
  function automatic int unitsPerRow(input int width);
    if (width >= LANE_BITS) return ROW_BITS / width;
    return NARROW_ROW / width;
  endfunction

  // Physical bit offset of a unit inside its row; narrow modes skip the ninth lane bit
  function automatic logic [OFF_W-1:0] bitOffset(input int width, input logic [UNIT_W-1:0] unit);
    int base;
    base = int'(unit) * width;
    if (width < LANE_BITS && base >= LANE_DATA) base = base + (LANE_BITS - LANE_DATA);
    return OFF_W'(base);
  endfunction

endpackage

// File: rtl/mwram_ctrl.sv
module mwram_ctrl
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 4,
  parameter int RD_WIDTH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ramStrobes_t       strb
);

  localparam int WR_UPR = unitsPerRow(WR_WIDTH);
  localparam int RD_UPR = unitsPerRow(RD_WIDTH);
  localparam int WR_UB  = $clog2(WR_UPR);
  localparam int RD_UB  = $clog2(RD_UPR);
  localparam logic [ADDR_W-1:0] WR_UMASK = ADDR_W'(WR_UPR - 1);
  localparam logic [ADDR_W-1:0] RD_UMASK = ADDR_W'(RD_UPR - 1);

  logic [UNIT_W-1:0] wrUnit;
  logic [UNIT_W-1:0] rdUnit;

  // Row index drops the unit bits; truncation to the row width discards any
  // address bits above the configured depth.
  always_comb begin
    wrUnit        = UNIT_W'(wrAddr & WR_UMASK);
    rdUnit        = UNIT_W'(rdAddr & RD_UMASK);
    strb.wrStb    = wrEn;
    strb.wrRow    = ROW_IDX_W'(wrAddr >> WR_UB);
    strb.wrOffset = bitOffset(WR_WIDTH, wrUnit);
    strb.rdStb    = rdEn;
    strb.rdRow    = ROW_IDX_W'(rdAddr >> RD_UB);
    strb.rdOffset = bitOffset(RD_WIDTH, rdUnit);
  end

  AST_WR_FITS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |-> (int'(strb.wrOffset) + WR_WIDTH <= ROW_BITS)); // R4
  AST_RD_FITS_ROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStb |-> (int'(strb.rdOffset) + RD_WIDTH <= ROW_BITS)); // R5

endmodule

// File: rtl/mwram_dpath.sv
module mwram_dpath
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 4,
  parameter int RD_WIDTH = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ramStrobes_t         strb,
  input  logic [WR_WIDTH-1:0] wrData,
  output logic [RD_WIDTH-1:0] rdData
);

  localparam logic [ROW_BITS-1:0] WR_ONES = ROW_BITS'((1 << WR_WIDTH) - 1);

  logic [ROW_BITS-1:0] mem [ROW_COUNT];
  logic [ROW_BITS-1:0] wrMask;
  logic [ROW_BITS-1:0] wrBits;
  logic [ROW_BITS-1:0] wrRowOld;
  logic [ROW_BITS-1:0] rdRowWord;

  always_comb begin
    wrMask    = WR_ONES << strb.wrOffset;
    wrBits    = ROW_BITS'(wrData) << strb.wrOffset;
    wrRowOld  = mem[strb.wrRow];
    rdRowWord = mem[strb.rdRow];
  end

  // Masked row update; bits outside the mask are rewritten with their own value
  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[strb.wrRow] <= (wrRowOld & ~wrMask) | (wrBits & wrMask);
  end

  // Array is sampled before the write lands, giving old data on a collision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdStb) rdData <= RD_WIDTH'(rdRowWord >> strb.rdOffset);
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStb |=> $stable(rdData)); // R3
  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> ((mem[$past(strb.wrRow)] & $past(wrMask)) == ($past(wrBits) & $past(wrMask)))); // R4
  AST_WR_KEEPS_REST: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |=> ((mem[$past(strb.wrRow)] & ~$past(wrMask)) == ($past(wrRowOld) & ~$past(wrMask)))); // R9
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStb |=> (mem[$past(strb.wrRow)] == $past(wrRowOld))); // R6

endmodule

// File: rtl/mwram_mixed.sv
module mwram_mixed
  import mwram_pkg::*;
#(
  parameter int WR_WIDTH = 4,
  parameter int RD_WIDTH = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WR_WIDTH-1:0] wrData,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [RD_WIDTH-1:0] rdData
);

  localparam bit WR_LEGAL = (WR_WIDTH == 1) || (WR_WIDTH == 2) || (WR_WIDTH == 4) ||
                            (WR_WIDTH == 9) || (WR_WIDTH == 18);
  localparam bit RD_LEGAL = (RD_WIDTH == 1) || (RD_WIDTH == 2) || (RD_WIDTH == 4) ||
                            (RD_WIDTH == 9) || (RD_WIDTH == 18);
  localparam bit SAME_FAMILY = (WR_WIDTH >= LANE_BITS) == (RD_WIDTH >= LANE_BITS);

  if (!(WR_LEGAL && RD_LEGAL && SAME_FAMILY)) begin : gBadCfg
    $error("mwram_mixed: unsupported width pairing");
  end

  ramStrobes_t strb;

  mwram_ctrl #(.WR_WIDTH(WR_WIDTH), .RD_WIDTH(RD_WIDTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  mwram_dpath #(.WR_WIDTH(WR_WIDTH), .RD_WIDTH(RD_WIDTH)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/mwram_mixed_tb_top.sv
`timescale 1ns/1ps
module mwram_mixed_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rstN;

  // Instance A: nibble writes, serial reads
  logic        aWrEn, aRdEn;
  logic [11:0] aWrAddr, aRdAddr;
  logic [3:0]  aWrData;
  logic [0:0]  aRdData;

  // Instance B: 18-bit writes, 9-bit reads
  logic        bWrEn, bRdEn;
  logic [11:0] bWrAddr, bRdAddr;
  logic [17:0] bWrData;
  logic [8:0]  bRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  mwram_mixed #(.WR_WIDTH(4), .RD_WIDTH(1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(aWrEn), .wrAddr(aWrAddr), .wrData(aWrData),
    .rdEn(aRdEn), .rdAddr(aRdAddr), .rdData(aRdData));

  mwram_mixed #(.WR_WIDTH(18), .RD_WIDTH(9)) dutWide_i (
    .clk(clk), .rstN(rstN), .wrEn(bWrEn), .wrAddr(bWrAddr), .wrData(bWrData),
    .rdEn(bRdEn), .rdAddr(bRdAddr), .rdData(bRdData));

  // {nibble address, nibble value}
  localparam logic [15:0] VEC [0:7] = '{
    {12'h000, 4'h5}, {12'h001, 4'hC}, {12'h002, 4'h3}, {12'h005, 4'h9},
    {12'h0FF, 4'hE}, {12'h200, 4'h7}, {12'h3FE, 4'h1}, {12'h3FF, 4'h8}};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrA(input logic [11:0] a, input logic [3:0] d);
    @(negedge clk); aWrEn = 1'b1; aWrAddr = a; aWrData = d;
    @(negedge clk); aWrEn = 1'b0;
  endtask

  task automatic rdA(input logic [11:0] a, output logic b);
    @(negedge clk); aRdEn = 1'b1; aRdAddr = a;
    @(negedge clk); b = aRdData[0]; aRdEn = 1'b0;
  endtask

  task automatic rdNibA(input logic [11:0] a, output logic [3:0] n);
    for (int k = 0; k < 4; k++) begin
      logic b;
      rdA({a[9:0], 2'(k)}, b);
      n[k] = b;
    end
  endtask

  task automatic wrB(input logic [11:0] a, input logic [17:0] d);
    @(negedge clk); bWrEn = 1'b1; bWrAddr = a; bWrData = d;
    @(negedge clk); bWrEn = 1'b0;
  endtask

  task automatic rdB(input logic [11:0] a, output logic [8:0] w);
    @(negedge clk); bRdEn = 1'b1; bRdAddr = a;
    @(negedge clk); w = bRdData; bRdEn = 1'b0;
  endtask

  initial begin
    logic [3:0] nib;
    logic       bit1;
    logic [8:0] word9;
    logic [17:0] w18;

    rstN = 1'b0;
    aWrEn = 0; aRdEn = 0; aWrAddr = '0; aRdAddr = '0; aWrData = '0;
    bWrEn = 0; bRdEn = 0; bWrAddr = '0; bRdAddr = '0; bWrData = '0;
    repeat (3) @(negedge clk);
    check(aRdData == 1'b0, "R1 in reset A", 32'(aRdData), 0);
    check(bRdData == 9'd0, "R1 in reset B", 32'(bRdData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(bRdData == 9'd0, "R1 after release", 32'(bRdData), 0);

    // Table: write every nibble, then read each back one bit at a time
    for (int i = 0; i < 8; i++) wrA(VEC[i][15:4], VEC[i][3:0]);
    for (int i = 0; i < 8; i++) begin
      rdNibA(VEC[i][15:4], nib);
      check(nib == VEC[i][3:0], "R4 little-endian nibble to bits", 32'(nib), 32'(VEC[i][3:0]));
    end

    // R2: latency; bit address 1 holds 0, bit address 0 holds 1
    rdA(12'd1, bit1);
    @(negedge clk); aRdEn = 1'b1; aRdAddr = 12'd0;
    #1;
    check(aRdData == 1'b0, "R2 not before edge", 32'(aRdData), 0);
    @(negedge clk);
    check(aRdData == 1'b1, "R2 after one edge", 32'(aRdData), 1);
    // R3: hold with read disabled and address moved
    aRdEn = 1'b0; aRdAddr = 12'd1;
    repeat (3) @(negedge clk);
    check(aRdData == 1'b1, "R3 hold while idle", 32'(aRdData), 1);

    // R6: write data present but strobe low
    aWrEn = 1'b0; aWrAddr = 12'h000; aWrData = 4'hA;
    repeat (2) @(negedge clk);
    rdNibA(12'h000, nib);
    check(nib == 4'h5, "R6 disabled write ignored", 32'(nib), 32'h5);

    // R7: same-cycle read and write of nibble 1 bit 0 (old 0, new 1)
    @(negedge clk);
    aWrEn = 1'b1; aWrAddr = 12'h001; aWrData = 4'h3;
    aRdEn = 1'b1; aRdAddr = 12'd4;
    @(negedge clk);
    check(aRdData == 1'b0, "R7 old data on collision", 32'(aRdData), 0);
    aWrEn = 1'b0; aRdEn = 1'b0;
    rdNibA(12'h001, nib);
    check(nib == 4'h3, "R7 write took effect", 32'(nib), 32'h3);

    // R9: neighbours in the same row untouched
    rdNibA(12'h000, nib);
    check(nib == 4'h5, "R9 lower neighbour kept", 32'(nib), 32'h5);
    rdNibA(12'h002, nib);
    check(nib == 4'h3, "R9 upper neighbour kept", 32'(nib), 32'h3);

    // R8: high address bits ignored on the nibble port
    wrA(12'h402, 4'hA);
    rdNibA(12'h002, nib);
    check(nib == 4'hA, "R8 alias 0x402", 32'(nib), 32'hA);
    wrA(12'hC05, 4'h6);
    rdNibA(12'h005, nib);
    check(nib == 4'h6, "R8 alias 0xC05", 32'(nib), 32'h6);

    // R5: 18-bit word split into two 9-bit reads
    w18 = 18'h2B4C7;
    wrB(12'd3, w18);
    rdB(12'd6, word9);
    check(word9 == w18[8:0], "R5 low lane", 32'(word9), 32'(w18[8:0]));
    rdB(12'd7, word9);
    check(word9 == w18[17:9], "R5 high lane", 32'(word9), 32'(w18[17:9]));

    // R8 on the wide instance: write and read aliases
    w18 = 18'h1F00F;
    wrB(12'h105, w18);
    rdB(12'h00A, word9);
    check(word9 == w18[8:0], "R8 wide write alias", 32'(word9), 32'(w18[8:0]));
    rdB(12'h20B, word9);
    check(word9 == w18[17:9], "R8 read alias 0x20B", 32'(word9), 32'(w18[17:9]));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule